// File: doc/BRIEF.md
# Processor Wake-Up Interrupt Sequencer

This block sends inter-processor interrupts through a two-word command register. The upper word holds the destination and the lower word holds the command. A single start pulse runs a complete wake-up of a remote processor. The block sends a reset-class message, waits a programmable number of microseconds, and then sends two identical start-up messages with a second timed gap between them. The destination ID, start address and broadcast select are captured on the start pulse. Later changes on those inputs have no effect until the next sequence.

Each message follows the same handshake:

1. Capture the current upper word.
2. Wait until the delivery-busy flag reads low.
3. Write the destination into the upper word.
4. Write the command into the lower word, which launches the message.
5. Wait for the busy flag to drop again.
6. Write the captured upper word back.

The interrupt fabric itself lives outside the block. The block sees it only as the busy flag and the current upper-word value. Delays are counted in one-cycle microsecond ticks supplied from outside, so a test can shorten the time base.

Top module: `ipi_startup_seq`

## Requirements
- R1: After reset, `hiWrEn`, `loWrEn`, `done` and `err` are all low, and no write occurs until a start is accepted.
- R2: Before each message, the current `icrHighIn` is captured. No destination write occurs while `deliveryBusy` is high.
- R3: The destination write puts the captured 8-bit ID in bits 31:24 of `wrData`, with zeros elsewhere. It always comes in the cycle just before that message's lower-word write.
- R4: The lower-word write launches a message. The first message is the reset-class one: vector 0 in bits 7:0, delivery mode 5 in bits 10:8, level bit 14 set, giving 0x0000_4500 without broadcast.
- R5: After each launch, the block waits until `deliveryBusy` is low and then writes the captured upper word back. The upper-word register ends each sequence holding its original value.
- R6: The second and third messages are identical start-up messages: delivery mode 6 in bits 10:8, level bit 14 set, and vector bits 7:0 equal to start address bits 19:12.
- R7: Between the first restore write and the next destination write, exactly `INIT_DELAY_US` ticks are counted. Between the second restore and the third destination write, exactly `GAP_DELAY_US` ticks are counted (default 200).
- R8: With broadcast selected, the destination word is zero and every command has shorthand value 3 in bits 19:18, which adds 0x000C_0000.
- R9: A start address of 1 MB or more, or one that is not 4 KB aligned, pulses `err` for one cycle in the cycle after the start. No write and no `done` follow.
- R10: `done` pulses for exactly one cycle after the final restore. No further writes follow until the next start.
- R11: A start pulse during a running sequence is ignored. Inputs changed after an accepted start do not alter that sequence's messages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to run the wake-up sequence |
| destId | input | 8 | Target processor ID, captured on start |
| startAddr | input | 32 | Start-up code address, captured on start |
| broadcast | input | 1 | Send to all processors except self |
| usTick | input | 1 | One-cycle pulse per microsecond |
| icrHighIn | input | 32 | Current value of the command upper word |
| deliveryBusy | input | 1 | Delivery-busy flag of the command register |
| hiWrEn | output | 1 | Write strobe for the upper word |
| loWrEn | output | 1 | Write strobe for the lower word (launch) |
| wrData | output | 32 | Data for whichever word is written |
| done | output | 1 | Sequence finished (one-cycle pulse) |
| err | output | 1 | Start address rejected (one-cycle pulse) |

## Verification
The properties take for granted that `deliveryBusy` is only raised by the fabric after a launch or held by the environment before one. They also assume it never rises between the busy-wait ending and the write that follows.

The bench fabric model satisfies this: it raises busy on the edge that samples `loWrEn`, holds it for a few cycles, and otherwise only forces busy before a start. The tick pulse has a period of four cycles, so no tick falls in the short window between a gap ending and the following destination write. This keeps the expected tick counts exact.

// File: rtl/ipi_seq_pkg.sv
package ipi_seq_pkg;
  localparam int WORD_W = 32;

  localparam logic [2:0] MODE_RESET   = 3'd5;
  localparam logic [2:0] MODE_STARTUP = 3'd6;
  localparam int         LEVEL_POS    = 14;
  localparam int         SHORT_LSB    = 18;
  localparam logic [1:0] SHORT_OTHERS = 2'd3;

  typedef enum logic [3:0] {
    ST_IDLE, ST_SAVE, ST_PRE_WAIT, ST_DEST, ST_LAUNCH,
    ST_POST_WAIT, ST_RESTORE, ST_GAP, ST_FINISH
  } seqState_t;

  typedef struct packed {
    logic latchReq;
    logic saveHi;
    logic selDest;
    logic selCmd;
    logic selRestore;
    logic clrDelay;
  } seqStrobes_t;

  function automatic logic addrAcceptable(input logic [WORD_W-1:0] a);
    return (a[WORD_W-1:20] == '0) && (a[11:0] == 12'h000);
  endfunction
endpackage

// File: rtl/ipi_seq_datapath.sv
module ipi_seq_datapath
  import ipi_seq_pkg::*;
#(
  parameter int ID_W          = 8,
  parameter int INIT_DELAY_US = 10000,
  parameter int GAP_DELAY_US  = 200
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       strb,
  input  logic              msgIsStartup,
  input  logic              delayIsInit,
  input  logic [ID_W-1:0]   destId,
  input  logic [WORD_W-1:0] startAddr,
  input  logic              broadcast,
  input  logic              usTick,
  input  logic [WORD_W-1:0] icrHighIn,
  output logic [WORD_W-1:0] wrData,
  output logic              delayDone
);
  localparam int MAX_DELAY = (INIT_DELAY_US > GAP_DELAY_US) ? INIT_DELAY_US : GAP_DELAY_US;
  localparam int CNT_W     = $clog2(MAX_DELAY + 1);
  localparam logic [CNT_W-1:0] INIT_LAST = CNT_W'(INIT_DELAY_US - 1);
  localparam logic [CNT_W-1:0] GAP_LAST  = CNT_W'(GAP_DELAY_US - 1);

  logic [ID_W-1:0]   destQ;
  logic [WORD_W-1:0] addrQ;
  logic              bcastQ;
  logic [WORD_W-1:0] savedHi;
  logic [CNT_W-1:0]  tickCnt;
  logic [WORD_W-1:0] destWord;
  logic [WORD_W-1:0] cmdWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      destQ   <= '0;
      addrQ   <= '0;
      bcastQ  <= 1'b0;
      savedHi <= '0;
    end else begin
      if (strb.latchReq) begin
        destQ  <= destId;
        addrQ  <= startAddr;
        bcastQ <= broadcast;
      end
      if (strb.saveHi) savedHi <= icrHighIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.clrDelay) tickCnt <= '0;
    else if (usTick)            tickCnt <= tickCnt + 1'b1;
  end

  assign delayDone = usTick && (tickCnt == (delayIsInit ? INIT_LAST : GAP_LAST));

  always_comb begin
    destWord = '0;
    if (!bcastQ) destWord[WORD_W-1 -: ID_W] = destQ;

    cmdWord = '0;
    cmdWord[7:0]       = msgIsStartup ? addrQ[19:12] : 8'h00;
    cmdWord[10:8]      = msgIsStartup ? MODE_STARTUP : MODE_RESET;
    cmdWord[LEVEL_POS] = 1'b1;
    cmdWord[SHORT_LSB +: 2] = bcastQ ? SHORT_OTHERS : 2'b00;

    unique case (1'b1)
      strb.selDest:    wrData = destWord;
      strb.selCmd:     wrData = cmdWord;
      strb.selRestore: wrData = savedHi;
      default:         wrData = '0;
    endcase
  end
endmodule

// File: rtl/ipi_seq_ctrl.sv
module ipi_seq_ctrl
  import ipi_seq_pkg::*;
#(
  parameter int MSG_COUNT = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        addrOk,
  input  logic        busy,
  input  logic        delayDone,
  output seqStrobes_t strb,
  output logic        msgIsStartup,
  output logic        delayIsInit,
  output logic        hiWrEn,
  output logic        loWrEn,
  output logic        done,
  output logic        err
);
  localparam int IDX_W = $clog2(MSG_COUNT);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(MSG_COUNT - 1);

  seqState_t        state, nextState;
  logic [IDX_W-1:0] msgIdx;
  logic             errQ;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:      if (start && addrOk) nextState = ST_SAVE;
      ST_SAVE:      nextState = ST_PRE_WAIT;
      ST_PRE_WAIT:  if (!busy) nextState = ST_DEST;
      ST_DEST:      nextState = ST_LAUNCH;
      ST_LAUNCH:    nextState = ST_POST_WAIT;
      ST_POST_WAIT: if (!busy) nextState = ST_RESTORE;
      ST_RESTORE:   nextState = (msgIdx == LAST_IDX) ? ST_FINISH : ST_GAP;
      ST_GAP:       if (delayDone) nextState = ST_SAVE;
      ST_FINISH:    nextState = ST_IDLE;
      default:      nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      msgIdx <= '0;
      errQ   <= 1'b0;
    end else begin
      state <= nextState;
      errQ  <= (state == ST_IDLE) && start && !addrOk;
      if (state == ST_IDLE && start)      msgIdx <= '0;
      else if (state == ST_GAP && delayDone) msgIdx <= msgIdx + 1'b1;
    end
  end

  always_comb begin
    strb            = '0;
    strb.latchReq   = (state == ST_IDLE) && start;
    strb.saveHi     = (state == ST_SAVE);
    strb.selDest    = (state == ST_DEST);
    strb.selCmd     = (state == ST_LAUNCH);
    strb.selRestore = (state == ST_RESTORE);
    strb.clrDelay   = (state == ST_RESTORE);
  end

  assign msgIsStartup = (msgIdx != '0);
  assign delayIsInit  = (msgIdx == '0);
  assign hiWrEn       = strb.selDest || strb.selRestore;
  assign loWrEn       = strb.selCmd;
  assign done         = (state == ST_FINISH);
  assign err          = errQ;
endmodule

// File: rtl/ipi_startup_seq.sv
module ipi_startup_seq
  import ipi_seq_pkg::*;
#(
  parameter int ID_W          = 8,
  parameter int INIT_DELAY_US = 10000,
  parameter int GAP_DELAY_US  = 200
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ID_W-1:0]   destId,
  input  logic [WORD_W-1:0] startAddr,
  input  logic              broadcast,
  input  logic              usTick,
  input  logic [WORD_W-1:0] icrHighIn,
  input  logic              deliveryBusy,
  output logic              hiWrEn,
  output logic              loWrEn,
  output logic [WORD_W-1:0] wrData,
  output logic              done,
  output logic              err
);
  seqStrobes_t strb;
  logic        msgIsStartup;
  logic        delayIsInit;
  logic        delayDone;

  ipi_seq_ctrl #(.MSG_COUNT(3)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .addrOk(addrAcceptable(startAddr)), .busy(deliveryBusy),
    .delayDone(delayDone), .strb(strb), .msgIsStartup(msgIsStartup),
    .delayIsInit(delayIsInit), .hiWrEn(hiWrEn), .loWrEn(loWrEn),
    .done(done), .err(err)
  );

  ipi_seq_datapath #(
    .ID_W(ID_W), .INIT_DELAY_US(INIT_DELAY_US), .GAP_DELAY_US(GAP_DELAY_US)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .msgIsStartup(msgIsStartup),
    .delayIsInit(delayIsInit), .destId(destId), .startAddr(startAddr),
    .broadcast(broadcast), .usTick(usTick), .icrHighIn(icrHighIn),
    .wrData(wrData), .delayDone(delayDone)
  );
endmodule

// File: rtl/ipi_seq_chk.sv
module ipi_seq_chk (
  input logic        clk,
  input logic        rstN,
  input logic        deliveryBusy,
  input logic        hiWrEn,
  input logic        loWrEn,
  input logic [31:0] wrData,
  input logic        done,
  input logic        err
);
  // R3
  dest_before_launch_chk: assert property (@(posedge clk) disable iff (!rstN)
    loWrEn |-> $past(hiWrEn));

  // R2
  idle_before_hi_chk: assert property (@(posedge clk) disable iff (!rstN)
    hiWrEn |-> !$past(deliveryBusy));

  // R4
  level_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    loWrEn |-> wrData[14]);

  // R5
  wait_after_launch_chk: assert property (@(posedge clk) disable iff (!rstN)
    loWrEn |=> !hiWrEn && !loWrEn);

  // R4
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    hiWrEn |-> !loWrEn);

  // R9
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    err |-> !hiWrEn && !loWrEn && !done);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done && !loWrEn);
endmodule

bind ipi_startup_seq ipi_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .deliveryBusy(deliveryBusy), .hiWrEn(hiWrEn),
  .loWrEn(loWrEn), .wrData(wrData), .done(done), .err(err)
);

// File: tb/sim_ipi_startup_seq.sv
`timescale 1ns/1ps
module sim_ipi_startup_seq;
  localparam int INIT_D = 12;
  localparam int GAP_D  = 200;
  localparam logic [31:0] HI_INIT = 32'h3C00_00A5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  destId = '0;
  logic [31:0] startAddr = '0;
  logic        broadcast = 1'b0;
  logic        usTick;
  logic [31:0] icrHigh;
  logic        deliveryBusy;
  logic        forceBusy = 1'b0;
  logic        hiWrEn, loWrEn, done, err;
  logic [31:0] wrData;

  always #4 clk = ~clk;

  ipi_startup_seq #(.INIT_DELAY_US(INIT_D), .GAP_DELAY_US(GAP_D)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .destId(destId),
    .startAddr(startAddr), .broadcast(broadcast), .usTick(usTick),
    .icrHighIn(icrHigh), .deliveryBusy(deliveryBusy), .hiWrEn(hiWrEn),
    .loWrEn(loWrEn), .wrData(wrData), .done(done), .err(err)
  );

  // fabric model, tick source and event log
  logic [1:0]  tickDiv;
  logic [2:0]  busyCnt;
  logic [31:0] hiData [0:63];
  int          hiTicks [0:63];
  int          loHiIdx [0:63];
  logic [31:0] loData [0:63];
  int hiCnt, loCnt, doneCnt, tickSince, cyc;
  int checks = 0, fails = 0;

  assign deliveryBusy = (busyCnt != 0) || forceBusy;

  always @(posedge clk) begin
    if (!rstN) begin
      tickDiv <= '0; usTick <= 1'b0; busyCnt <= '0; icrHigh <= HI_INIT;
      hiCnt <= 0; loCnt <= 0; doneCnt <= 0; tickSince <= 0;
    end else begin
      tickDiv <= tickDiv + 1'b1;
      usTick  <= (tickDiv == 2'd3);
      if (loWrEn) busyCnt <= 3'd4;
      else if (busyCnt != 0) busyCnt <= busyCnt - 1'b1;
      if (hiWrEn) begin
        icrHigh <= wrData;
        hiData[hiCnt] <= wrData;
        hiTicks[hiCnt] <= tickSince;
        hiCnt <= hiCnt + 1;
        tickSince <= 0;
      end else if (usTick) tickSince <= tickSince + 1;
      if (loWrEn) begin
        loData[loCnt] <= wrData;
        loHiIdx[loCnt] <= hiCnt;
        loCnt <= loCnt + 1;
      end
      if (done) doneCnt <= doneCnt + 1;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks + 1, fails + 1);
      $finish;
    end
  end
  initial cyc = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic test_reset();
    chk(!hiWrEn && !loWrEn && !done && !err, "R1 reset outputs",
        {28'b0, hiWrEn, loWrEn, done, err}, 32'h0);
    repeat (10) @(negedge clk);
    chk(hiCnt == 0 && loCnt == 0, "R1 no write without start", hiCnt + loCnt, 0);
  endtask

  task automatic run_seq(input logic [7:0] dest, input logic [31:0] addr, input bit bc,
                         input bit preBusy, input bit restartMid);
    int hB, lB, dB, guard;
    logic [31:0] sh, expDest, expInit, expStart;
    hB = hiCnt; lB = loCnt; dB = doneCnt;
    sh = bc ? 32'h000C_0000 : 32'h0;
    expDest  = bc ? 32'h0 : {dest, 24'h0};
    expInit  = 32'h0000_4500 | sh;
    expStart = 32'h0000_4600 | sh | {24'h0, addr[19:12]};
    @(negedge clk);
    forceBusy = preBusy;
    destId = dest; startAddr = addr; broadcast = bc; start = 1'b1;
    @(negedge clk);
    start = 1'b0; destId = ~dest; startAddr = 32'h0001_2345; broadcast = ~bc;
    if (preBusy) begin
      repeat (20) @(negedge clk);
      chk(hiCnt == hB, "R2 held while busy", hiCnt - hB, 0);
      forceBusy = 1'b0;
    end
    if (restartMid) begin
      guard = 0;
      while (loCnt == lB && guard < 1000) begin @(negedge clk); guard++; end
      startAddr = 32'h0008_8000; destId = 8'h77; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    guard = 0;
    while (doneCnt == dB && guard < 100000) begin @(negedge clk); guard++; end
    repeat (30) @(negedge clk);
    chk(hiCnt - hB == 6, "R10 upper writes per sequence", hiCnt - hB, 6);
    chk(loCnt - lB == 3, "R11 launches per sequence", loCnt - lB, 3);
    chk(doneCnt - dB == 1, "R10 single done", doneCnt - dB, 1);
    for (int i = 0; i < 3; i++) begin
      chk(hiData[hB + 2*i] == expDest, "R3 destination word", hiData[hB + 2*i], expDest);
      chk(hiData[hB + 2*i + 1] == HI_INIT, "R5 restored word", hiData[hB + 2*i + 1], HI_INIT);
      chk(loHiIdx[lB + i] == hB + 2*i + 1, "R3 destination precedes launch",
          loHiIdx[lB + i], hB + 2*i + 1);
    end
    chk(loData[lB] == expInit, "R4 reset-class command", loData[lB], expInit);
    chk(loData[lB + 1] == expStart, "R6 first start-up command", loData[lB + 1], expStart);
    chk(loData[lB + 2] == expStart, "R6 second start-up command", loData[lB + 2], expStart);
    if (bc) chk(loData[lB] [19:18] == 2'd3, "R8 shorthand field", loData[lB], expInit);
    chk(hiTicks[hB + 2] == INIT_D, "R7 first gap ticks", hiTicks[hB + 2], INIT_D);
    chk(hiTicks[hB + 4] == GAP_D, "R7 second gap ticks", hiTicks[hB + 4], GAP_D);
    chk(icrHigh == HI_INIT, "R5 upper word intact", icrHigh, HI_INIT);
  endtask

  task automatic bad_addr(input logic [31:0] addr);
    int hB, lB, dB;
    hB = hiCnt; lB = loCnt; dB = doneCnt;
    @(negedge clk);
    startAddr = addr; destId = 8'h11; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(err == 1'b1, "R9 err raised", err, 1);
    @(negedge clk);
    chk(err == 1'b0, "R9 err one cycle", err, 0);
    repeat (40) @(negedge clk);
    chk(hiCnt == hB && loCnt == lB && doneCnt == dB, "R9 nothing issued",
        (hiCnt - hB) + (loCnt - lB) + (doneCnt - dB), 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    test_reset();
    run_seq(8'h2A, 32'h0009_F000, 1'b0, 1'b0, 1'b0);
    run_seq(8'hFF, 32'h0000_1000, 1'b1, 1'b0, 1'b0);
    run_seq(8'h05, 32'h000F_F000, 1'b0, 1'b1, 1'b0);
    run_seq(8'h81, 32'h0004_0000, 1'b0, 1'b0, 1'b1);
    bad_addr(32'h0010_0000);
    bad_addr(32'h0009_F800);
    run_seq(8'h00, 32'h0000_0000, 1'b1, 1'b1, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule